// File: doc/BRIEF.md
# Split-Byte Conversion Result Holder

This block keeps the most recent 10-bit conversion value and shows it to a processor as two byte-wide, read-only registers, a high byte and a low byte. The converter delivers a one-cycle completion strobe together with the value, and the bus side issues one-cycle read strobes for the low or the high byte. The block returns the selected byte on a shared read-data bus.

A single alignment input chooses how the 10 bits are packed into the two bytes. Right alignment suits full-precision reads. Left alignment puts the eight most significant bits in the high byte, so one high-byte read gives an 8-bit result. Software that wants all 10 bits reads the low byte first and the high byte second. The low-byte read freezes the stored value until the high byte has been read, so a new conversion cannot mix bytes from two results. A conversion that arrives while the value is frozen is dropped, and a sticky flag reports the loss.

Top module: `convres_bytes`

## Requirements
- R1: After reset the stored value is zero, the loss flag `lost` is 0 and the block is unfrozen.
- R2: A completion strobe while the block is unfrozen stores `conv_data`. The new value is visible on reads from the next cycle.
- R3: With `left_align` = 0, a high-byte read returns {6'b0, value[9:8]} and a low-byte read returns value[7:0].
- R4: With `left_align` = 1, a high-byte read returns value[9:2] and a low-byte read returns {value[1:0], 6'b0}.
- R5: A low-byte read freezes the stored value from the next cycle onward. While frozen, completion strobes leave the stored value unchanged.
- R6: A high-byte read unfreezes the block from the next cycle onward.
- R7: A completion strobe that is dropped sets `lost` on the next cycle. The flag stays set until a high-byte read clears it, and the clear takes effect on the next cycle.
- R8: A high-byte read on an unfrozen block leaves it unfrozen. A following completion strobe is stored.
- R9: `left_align` is applied combinationally at read time. Changing it remaps the stored value on the same cycle, with no new conversion.
- R10: A completion strobe in the same cycle as an unfreezing high-byte read is stored. A completion strobe in the same cycle as a low-byte read is dropped, because the byte being read must stay consistent.
- R11: `rd_data` is zero in any cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle conversion completion strobe |
| conv_data | input | 10 | Conversion value, valid with `conv_done` |
| left_align | input | 1 | 0: right-aligned packing, 1: left-aligned packing |
| rd_lo | input | 1 | Low-byte read strobe |
| rd_hi | input | 1 | High-byte read strobe |
| rd_data | output | 8 | Selected byte, zero when no read strobe |
| lost | output | 1 | Sticky flag: a completion strobe was dropped |

## Verification
Two functions can collide in one cycle: a completion strobe can coincide with the high-byte read that unfreezes the block, or with the low-byte read that freezes it. The bench drives both collisions on purpose, including with the block already frozen. A behavioural reference model predicts the outcome: the value is stored in the first case and dropped in the second. That prediction is compared against `rd_data` and `lost` on every clock. Follow-up reads then confirm which value was kept and whether the loss flag was set.

// File: rtl/convres_bytes.sv
module convres_bytes #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  input  logic              left_align,
  input  logic              rd_lo,
  input  logic              rd_hi,
  output logic [BYTE_W-1:0] rd_data,
  output logic              lost
);
  localparam int EXTRA = RES_W - BYTE_W;
  localparam int PAD   = BYTE_W - EXTRA;

  logic [RES_W-1:0]  res;
  logic              locked;
  logic              take, drop;
  logic [BYTE_W-1:0] hi_byte, lo_byte;

  assign take = conv_done && !rd_lo && (!locked || rd_hi);
  assign drop = conv_done && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res    <= '0;
      locked <= 1'b0;
      lost   <= 1'b0;
    end else begin
      if (take) res <= conv_data;
      if (rd_lo)      locked <= 1'b1;
      else if (rd_hi) locked <= 1'b0;
      if (drop)       lost <= 1'b1;
      else if (rd_hi) lost <= 1'b0;
    end
  end

  assign hi_byte = left_align ? res[RES_W-1 -: BYTE_W]
                              : {{PAD{1'b0}}, res[RES_W-1:BYTE_W]};
  assign lo_byte = left_align ? {res[EXTRA-1:0], {PAD{1'b0}}}
                              : res[BYTE_W-1:0];

  assign rd_data = rd_hi ? hi_byte : (rd_lo ? lo_byte : '0);
endmodule

// File: rtl/convres_bytes_chk.sv
module convres_bytes_chk #(
  parameter int RES_W  = 10,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_done,
  input logic [RES_W-1:0]  conv_data,
  input logic              left_align,
  input logic              rd_lo,
  input logic              rd_hi,
  input logic [BYTE_W-1:0] rd_data,
  input logic              lost,
  input logic              locked,
  input logic [RES_W-1:0]  res
);
  localparam int PAD = 2*BYTE_W - RES_W;

  assert_hi_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !left_align) |-> rd_data[BYTE_W-1 -: PAD] == '0);

  assert_lo_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && !rd_hi && left_align) |-> rd_data[PAD-1:0] == '0);

  assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !rd_hi) |=> $stable(res));

  assert_drop_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && rd_lo) |=> lost);

  assert_hi_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !conv_done) |=> !lost);

  assert_same_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && rd_hi && !rd_lo) |=> res == $past(conv_data));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_lo && !rd_hi) |-> rd_data == '0);
endmodule

bind convres_bytes convres_bytes_chk #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_convres_bytes.sv
`timescale 1ns/1ps
module sim_convres_bytes;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic       left_align = 1'b0;
  logic       rd_lo = 1'b0;
  logic       rd_hi = 1'b0;
  logic [7:0] rd_data;
  logic       lost;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_res  = 0;
  bit m_lock = 0;
  bit m_lost = 0;

  always #2 clk = ~clk;

  convres_bytes u0 (.*);

  function automatic int expect_byte(int v, bit la, bit lo, bit hi);
    if (hi) return la ? (v >> 2) & 8'hFF : (v >> 8) & 8'h03;
    if (lo) return la ? ((v & 3) << 6) : v & 8'hFF;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit cd, int d, bit la, bit lo, bit hi, string tag);
    bit tk;
    @(negedge clk);
    conv_done = cd; conv_data = d[9:0]; left_align = la; rd_lo = lo; rd_hi = hi;
    #1;
    check(tag, rd_data, expect_byte(m_res, la, lo, hi), "rd_data");
    check(tag, lost, m_lost, "lost");
    @(posedge clk);
    tk = cd && !lo && (!m_lock || hi);
    if (tk) m_res = d;
    if (cd && !tk) m_lost = 1;
    else if (hi) m_lost = 0;
    if (lo) m_lock = 1;
    else if (hi) m_lock = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    cyc(0, 0, 0, 1, 0, "R1");
    cyc(0, 0, 1, 0, 1, "R1");
    cyc(0, 0, 0, 0, 0, "R11");
    // R2 capture, R3 right packing
    cyc(1, 10'h2A5, 0, 0, 0, "R2");
    cyc(0, 0, 0, 1, 0, "R3");
    cyc(0, 0, 0, 0, 1, "R3");
    // R4 left packing, R9 remap on the fly
    cyc(0, 0, 1, 0, 1, "R4");
    cyc(0, 0, 1, 1, 0, "R4");
    cyc(0, 0, 0, 0, 1, "R9");
    cyc(0, 0, 1, 0, 1, "R9");
    cyc(1, 10'h3FF, 0, 0, 0, "R2");
    cyc(0, 0, 1, 0, 0, "R11");
    cyc(0, 0, 1, 1, 0, "R4");
    // R5 freeze, R7 loss flag
    cyc(0, 0, 0, 1, 0, "R5");
    cyc(1, 10'h111, 0, 0, 0, "R5");
    cyc(0, 0, 0, 0, 0, "R7");
    cyc(1, 10'h0F0, 1, 1, 0, "R5");
    cyc(0, 0, 0, 0, 1, "R6");
    cyc(0, 0, 0, 0, 0, "R7");
    // R6 unfrozen again
    cyc(1, 10'h155, 0, 0, 0, "R6");
    cyc(0, 0, 0, 1, 0, "R6");
    cyc(0, 0, 0, 0, 1, "R6");
    // R8 high read alone
    cyc(0, 0, 1, 0, 1, "R8");
    cyc(1, 10'h0C3, 0, 0, 0, "R8");
    cyc(0, 0, 0, 1, 0, "R8");
    cyc(0, 0, 0, 0, 1, "R8");
    // R10 collisions
    cyc(0, 0, 0, 1, 0, "R10");
    cyc(1, 10'h2DB, 0, 0, 1, "R10");
    cyc(0, 0, 0, 1, 0, "R10");
    cyc(1, 10'h001, 0, 0, 1, "R10");
    cyc(1, 10'h3C0, 1, 1, 0, "R10");
    cyc(0, 0, 1, 0, 1, "R10");
    cyc(0, 0, 0, 0, 0, "R7");
    for (int i = 0; i < 40; i++)
      cyc((i % 3) == 0, (i * 97) & 10'h3FF, i[2], (i % 5) == 1, (i % 7) == 3, "R2");
    cyc(0, 0, 0, 0, 0, "R11");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule